// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC. It watches the first six bytes of each incoming frame, which carry the destination address, and decides whether the frame is kept or thrown away. A frame is kept when one of the following holds:

- it matches one of two programmable exact addresses;
- it is the all-ones broadcast address and broadcast acceptance is on;
- it hits a 64-entry single-hash group table.

The hash index folds the 48 address bits into 6 bits with XOR.

Configuration is written through a small select/data port. The values in force are copied into a working snapshot when a frame starts, so software may reprogram the filter while traffic flows. A frame's length arrives with its first byte. Frames below the minimum length are dropped whatever their address.

The control logic is a two-state machine:

- `S_IDLE` waits for a start beat.
- `S_HDR` collects the remaining address bytes.

There are three transitions:

- `S_IDLE` goes to `S_HDR` on a start beat.
- `S_HDR` returns to `S_IDLE` on the sixth byte, which also issues the decision.
- `S_HDR` stays in `S_HDR` on a new start beat, which restarts collection.

Top module: `rx_addr_filter`

## Requirements
- R1: When control bit 0 is set, an address equal to exact slot 0 is accepted; when bit 0 is clear, slot 0 has no effect. Slot 0 is written at select 0 (low word) and select 1 (high word).
- R2: When control bit 1 is set, an address equal to exact slot 1 is accepted; when bit 1 is clear, slot 1 has no effect. Slot 1 is written at select 2 (low word) and select 3 (high word).
- R3: When control bit 3 is set, the address FF:FF:FF:FF:FF:FF is accepted. The control word is written at select 6.
- R4: The hash index is formed as follows:
  - Number the address bits 0 to 47, with byte 0 in bits 7:0 and bit 0 of byte 0 first.
  - Bit i contributes to index bit (i mod 6), and the contributions are combined by XOR.
  - Indices 0 to 31 select a bit of the table word at select 4.
  - Indices 32 to 63 select bit (index-32) of the table word at select 5.
  - A set table bit accepts the frame.
- R5: A hash hit can accept a frame only when bit 0 of byte 0 is 1 or control bit 2 is set.
- R6: A frame whose length, sampled with its first byte, is below 12 is dropped even if its address matches.
- R7: The decision appears on `flt_valid` for exactly one cycle, in the cycle after the sixth address byte is taken. `flt_accept` is never high without `flt_valid`.
- R8: A configuration write affects only frames whose start beat comes in a later cycle than the write. This includes a write in the same cycle as the start beat.
- R9: Each slot's low word holds bytes 0 to 3, with byte 0 in bits 7:0. Its high word holds bytes 4 and 5 in bits 15:0.
- R10: A start beat during address collection abandons the current frame, and the abandoned frame produces no decision.
- R11: After reset, `flt_valid` and `flt_accept` are low, and all configuration is zero, so every frame is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 3 | Configuration register select (0 to 6) |
| cfg_wr_data | input | 32 | Configuration write data |
| rx_beat | input | 1 | A frame byte is present this cycle |
| rx_sof | input | 1 | The present byte is the first byte of a frame |
| rx_len | input | LEN_W | Frame length in bytes, sampled on the first byte |
| rx_byte | input | 8 | Frame byte |
| flt_valid | output | 1 | Decision strobe |
| flt_accept | output | 1 | Accept (1) or drop (0), qualified by `flt_valid` |

## Verification
A configuration write and a frame start can land in the same cycle. A write can also arrive while address bytes are still being gathered. Both are provoked by raising the write strobe on a chosen beat of a frame: the start beat or a middle beat. The write either disables the matching source or enables a new one. The bench then checks that the current frame is judged with the old settings and the following frame with the new ones.

// File: rtl/rx_filt_pkg.sv
`timescale 1ns/1ps
package rx_filt_pkg;
    localparam int FILT_ADDR_W = 48;
    localparam int FILT_IDX_W  = 6;
    localparam int FILT_TAB_W  = 1 << FILT_IDX_W;
    localparam int FILT_SLOTS  = 2;
    localparam int FILT_CTL_W  = 4;

    // control word bit positions
    localparam int CTL_SLOT0 = 0;
    localparam int CTL_INDIV = 2;
    localparam int CTL_BCAST = 3;

    typedef enum logic [2:0] {
        SEL_S0_LO = 3'd0,
        SEL_S0_HI = 3'd1,
        SEL_S1_LO = 3'd2,
        SEL_S1_HI = 3'd3,
        SEL_TAB_LO = 3'd4,
        SEL_TAB_HI = 3'd5,
        SEL_CTL   = 3'd6
    } cfg_sel_e;

    typedef struct packed {
        logic [FILT_SLOTS-1:0][FILT_ADDR_W-1:0] slot;
        logic [FILT_TAB_W-1:0]                  gtab;
        logic [FILT_CTL_W-1:0]                  ctrl;
    } filt_cfg_t;
endpackage

// File: rtl/filt_cfg_regs.sv
`timescale 1ns/1ps
module filt_cfg_regs
    import rx_filt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    output filt_cfg_t         snap
);
    localparam int HI_W = FILT_ADDR_W - DATA_W;

    logic [FILT_SLOTS-1:0][DATA_W-1:0] lo_q;
    logic [FILT_SLOTS-1:0][HI_W-1:0]   hi_q;
    logic [DATA_W-1:0]                 tlo_q, thi_q;
    logic [FILT_CTL_W-1:0]             ctl_q;
    filt_cfg_t                         live;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            tlo_q <= '0;
            thi_q <= '0;
            ctl_q <= '0;
        end else if (wr_en) begin
            unique case (cfg_sel_e'(wr_sel))
                SEL_S0_LO:  lo_q[0] <= wr_data;
                SEL_S0_HI:  hi_q[0] <= wr_data[HI_W-1:0];
                SEL_S1_LO:  lo_q[1] <= wr_data;
                SEL_S1_HI:  hi_q[1] <= wr_data[HI_W-1:0];
                SEL_TAB_LO: tlo_q   <= wr_data;
                SEL_TAB_HI: thi_q   <= wr_data;
                SEL_CTL:    ctl_q   <= wr_data[FILT_CTL_W-1:0];
                default:    ;
            endcase
        end
    end

    always_comb begin
        for (int s = 0; s < FILT_SLOTS; s++) begin
            live.slot[s] = {hi_q[s], lo_q[s]};
        end
        live.gtab = {thi_q, tlo_q};
        live.ctrl = ctl_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    snap <= '0;
        else if (load) snap <= live;
    end

    // R8: working copy changes only on a frame start
    p_snap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(snap));
endmodule

// File: rtl/filt_hash.sv
`timescale 1ns/1ps
module filt_hash
    import rx_filt_pkg::*;
#(
    parameter int ADDR_W = FILT_ADDR_W,
    parameter int IDX_W  = FILT_IDX_W
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [(1<<IDX_W)-1:0]  gtab,
    input  logic                   indiv_en,
    output logic                   hash_hit
);
    localparam int NCH = ADDR_W / IDX_W;

    logic [NCH:0][IDX_W-1:0] fold;
    assign fold[0] = '0;

    for (genvar g = 0; g < NCH; g++) begin : g_fold
        assign fold[g+1] = fold[g] ^ addr[g*IDX_W +: IDX_W];
    end

    assign hash_hit = (addr[0] | indiv_en) & gtab[fold[NCH]];
endmodule

// File: rtl/filt_match.sv
`timescale 1ns/1ps
module filt_match
    import rx_filt_pkg::*;
(
    input  logic [FILT_ADDR_W-1:0] addr,
    input  filt_cfg_t              cfg,
    output logic                   exact_hit
);
    logic [FILT_SLOTS-1:0] slot_hit;

    for (genvar s = 0; s < FILT_SLOTS; s++) begin : g_slot
        assign slot_hit[s] = cfg.ctrl[CTL_SLOT0 + s] && (addr == cfg.slot[s]);
    end

    assign exact_hit = (|slot_hit) | (cfg.ctrl[CTL_BCAST] & (&addr));
endmodule

// File: rtl/rx_addr_filter.sv
`timescale 1ns/1ps
module rx_addr_filter
    import rx_filt_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 12,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [2:0]        cfg_wr_sel,
    input  logic [DATA_W-1:0] cfg_wr_data,
    input  logic              rx_beat,
    input  logic              rx_sof,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic [7:0]        rx_byte,
    output logic              flt_valid,
    output logic              flt_accept
);
    localparam int NB    = FILT_ADDR_W / 8;
    localparam int CNT_W = $clog2(NB);

    typedef enum logic {S_IDLE, S_HDR} st_e;

    st_e                   st_q, st_d;
    logic [CNT_W-1:0]      cnt_q, cnt_d;
    logic [FILT_ADDR_W-1:0] addr_q, addr_d;
    logic                  len_ok_q;
    logic                  start, last_beat;
    logic                  exact_hit, hash_hit;
    filt_cfg_t             cfg_act;

    assign start     = rx_beat && rx_sof;
    assign last_beat = rx_beat && !rx_sof && (st_q == S_HDR) &&
                       (cnt_q == CNT_W'(NB-1));

    filt_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel),
        .wr_data(cfg_wr_data), .load(start), .snap(cfg_act)
    );

    filt_match u_match (.addr(addr_d), .cfg(cfg_act), .exact_hit(exact_hit));

    filt_hash u_hash (
        .addr(addr_d), .gtab(cfg_act.gtab),
        .indiv_en(cfg_act.ctrl[CTL_INDIV]), .hash_hit(hash_hit)
    );

    // next-state and address assembly
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        addr_d = addr_q;
        unique case (st_q)
            S_IDLE: begin
                if (start) begin
                    st_d        = S_HDR;
                    cnt_d       = CNT_W'(1);
                    addr_d      = '0;
                    addr_d[7:0] = rx_byte;
                end
            end
            S_HDR: begin
                if (start) begin
                    cnt_d       = CNT_W'(1);
                    addr_d      = '0;
                    addr_d[7:0] = rx_byte;
                end else if (rx_beat) begin
                    addr_d[{cnt_q, 3'b000} +: 8] = rx_byte;
                    if (last_beat) begin
                        st_d  = S_IDLE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= S_IDLE;
            cnt_q    <= '0;
            addr_q   <= '0;
            len_ok_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            addr_q <= addr_d;
            if (start) len_ok_q <= (rx_len >= LEN_W'(MIN_LEN));
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_valid  <= 1'b0;
            flt_accept <= 1'b0;
        end else begin
            flt_valid  <= last_beat;
            flt_accept <= last_beat & len_ok_q & (exact_hit | hash_hit);
        end
    end

    p_valid_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |=> flt_valid);
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> !flt_valid);
    p_accept_qualified_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flt_accept |-> flt_valid);
    p_short_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && !len_ok_q) |=> !flt_accept);
    p_bcast_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && len_ok_q && cfg_act.ctrl[CTL_BCAST] && (&addr_d)) |=> flt_accept);
    p_slot0_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && len_ok_q && cfg_act.ctrl[CTL_SLOT0] &&
         (addr_d == cfg_act.slot[0])) |=> flt_accept);
endmodule

// File: tb/sim_rx_addr_filter.sv
`timescale 1ns/1ps
module sim_rx_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_sel = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        rx_beat = 1'b0;
    logic        rx_sof = 1'b0;
    logic [15:0] rx_len = '0;
    logic [7:0]  rx_byte = '0;
    logic        flt_valid, flt_accept;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_lo [2];
    logic [15:0] m_hi [2];
    logic [31:0] m_glo, m_ghi;
    logic [3:0]  m_ctl;

    always #2 clk = ~clk;

    rx_addr_filter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .rx_beat(rx_beat), .rx_sof(rx_sof),
        .rx_len(rx_len), .rx_byte(rx_byte), .flt_valid(flt_valid),
        .flt_accept(flt_accept)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic m_apply(input int sel, input logic [31:0] d);
        case (sel)
            0: m_lo[0] = d;
            1: m_hi[0] = d[15:0];
            2: m_lo[1] = d;
            3: m_hi[1] = d[15:0];
            4: m_glo = d;
            5: m_ghi = d;
            6: m_ctl = d[3:0];
            default: ;
        endcase
    endtask

    function automatic logic [5:0] m_hash(input logic [47:0] a);
        logic [5:0] h;
        h = '0;
        for (int i = 0; i < 48; i++) h[i % 6] = h[i % 6] ^ a[i];
        return h;
    endfunction

    function automatic bit m_accept(input logic [47:0] a, input int len);
        logic [63:0] tab;
        bit ex0, ex1, bc, hh;
        tab = {m_ghi, m_glo};
        ex0 = m_ctl[0] && (a == {m_hi[0], m_lo[0]});
        ex1 = m_ctl[1] && (a == {m_hi[1], m_lo[1]});
        bc  = m_ctl[3] && (a == 48'hFFFF_FFFF_FFFF);
        hh  = (a[0] || m_ctl[2]) && tab[m_hash(a)];
        return (len >= 12) && (ex0 || ex1 || bc || hh);
    endfunction

    task automatic wr(input int sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = 3'(sel); cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        m_apply(sel, d);
    endtask

    // Drives n bytes of a frame; optional write on beat wr_at.
    task automatic drive_bytes(input logic [47:0] a, input int len, input int n,
                               input int wr_at, input int wsel, input logic [31:0] wdat,
                               output int early_valid);
        early_valid = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (flt_valid) early_valid++;
            rx_beat = 1'b1; rx_sof = (i == 0); rx_byte = a[8*i +: 8];
            rx_len = 16'(len);
            cfg_wr_en = (wr_at == i); cfg_wr_sel = 3'(wsel); cfg_wr_data = wdat;
        end
    endtask

    task automatic send(input logic [47:0] a, input int len, input string req,
                        input int wr_at, input int wsel, input logic [31:0] wdat);
        bit exp;
        int ev;
        exp = m_accept(a, len);
        drive_bytes(a, len, 6, wr_at, wsel, wdat, ev);
        @(negedge clk);
        rx_beat = 1'b0; rx_sof = 1'b0; cfg_wr_en = 1'b0;
        chk(ev == 0, req, "no early valid", ev, 0);
        chk(flt_valid == 1'b1, req, "valid after sixth byte", int'(flt_valid), 1);
        chk(flt_accept == exp, req, "accept", int'(flt_accept), int'(exp));
        if (wr_at >= 0) m_apply(wsel, wdat);
        @(negedge clk);
        chk(flt_valid == 1'b0, req, "single-cycle valid", int'(flt_valid), 0);
    endtask

    function automatic logic [47:0] slot_addr(input int s);
        return {m_hi[s], m_lo[s]};
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int ev;
        logic [47:0] a;
        void'($urandom(32'd20240611));
        for (int s = 0; s < 2; s++) begin m_lo[s] = '0; m_hi[s] = '0; end
        m_glo = '0; m_ghi = '0; m_ctl = '0;
        repeat (3) @(negedge clk);
        chk(flt_valid == 1'b0 && flt_accept == 1'b0, "R11", "reset outputs",
            int'({flt_valid, flt_accept}), 0);
        rst_n = 1'b1;
        // R11: all-zero configuration drops everything, even broadcast
        send(48'hFFFF_FFFF_FFFF, 64, "R11", -1, 0, 0);
        send(48'h0000_0000_0001, 64, "R11", -1, 0, 0);

        // R9 / R1: slot 0 = bytes 02 11 22 33 44 55
        wr(0, 32'h3322_1102); wr(1, 32'hABCD_5544);
        send(48'h5544_3322_1102, 60, "R1", -1, 0, 0);   // ctrl off -> drop
        wr(6, 32'h1);
        send(48'h5544_3322_1102, 60, "R9", -1, 0, 0);   // accept
        send(48'h5544_3322_1103, 60, "R1", -1, 0, 0);   // near miss

        // R2: slot 1
        wr(2, 32'h0403_0201); wr(3, 32'h0605);
        send(48'h0605_0403_0201, 60, "R2", -1, 0, 0);   // bit1 clear -> drop
        wr(6, 32'h2);
        send(48'h0605_0403_0201, 60, "R2", -1, 0, 0);
        send(48'h5544_3322_1102, 60, "R1", -1, 0, 0);   // slot0 disabled now

        // R3: broadcast
        send(48'hFFFF_FFFF_FFFF, 60, "R3", -1, 0, 0);
        wr(6, 32'h8);
        send(48'hFFFF_FFFF_FFFF, 60, "R3", -1, 0, 0);

        // R4: index 1 -> table low bit 1; index 33 -> table high bit 1
        wr(6, 32'h0); wr(4, 32'h2); wr(5, 32'h0);
        send(48'h0000_0000_0001, 60, "R4", -1, 0, 0);
        send(48'h8000_0000_0001, 60, "R4", -1, 0, 0);   // idx 33 not set
        wr(4, 32'h0); wr(5, 32'h2);
        send(48'h8000_0000_0001, 60, "R4", -1, 0, 0);
        send(48'h0000_0000_0001, 60, "R4", -1, 0, 0);

        // R5: individual address hashing gated by ctrl bit 2
        a = 48'h1234_5678_9A02;
        wr(4, 32'hFFFF_FFFF); wr(5, 32'hFFFF_FFFF);
        send(a, 60, "R5", -1, 0, 0);
        wr(6, 32'h4);
        send(a, 60, "R5", -1, 0, 0);

        // R6: length boundary
        wr(6, 32'h1);
        wr(4, 32'h0); wr(5, 32'h0);
        send(48'h5544_3322_1102, 11, "R6", -1, 0, 0);
        send(48'h5544_3322_1102, 12, "R6", -1, 0, 0);

        // R8: write in the start cycle and mid-frame
        send(48'h5544_3322_1102, 60, "R8", 0, 6, 32'h0);   // old ctrl: accept
        send(48'h5544_3322_1102, 60, "R8", -1, 0, 0);      // new ctrl: drop
        send(48'h5544_3322_1102, 60, "R8", 3, 6, 32'h1);   // old: drop
        send(48'h5544_3322_1102, 60, "R8", -1, 0, 0);      // new: accept

        // R10: restart while collecting
        drive_bytes(48'hFFFF_FFFF_FFFF, 60, 3, -1, 0, 0, ev);
        chk(ev == 0, "R10", "no valid on abandoned part", ev, 0);
        send(48'h5544_3322_1102, 60, "R10", -1, 0, 0);
        drive_bytes(48'h5544_3322_1102, 60, 5, -1, 0, 0, ev);
        send(48'h0000_0000_0004, 60, "R10", -1, 0, 0);

        // R7 and all sources: constrained random
        for (int it = 0; it < 300; it++) begin
            int pick;
            if ($urandom_range(0, 7) == 0) begin
                wr(0, $urandom()); wr(1, $urandom()); wr(2, $urandom());
                wr(3, $urandom()); wr(4, $urandom() & $urandom());
                wr(5, $urandom() & $urandom()); wr(6, $urandom());
            end
            pick = $urandom_range(0, 4);
            case (pick)
                0: a = slot_addr(0);
                1: a = slot_addr(1);
                2: a = 48'hFFFF_FFFF_FFFF;
                3: a = {$urandom(), $urandom()} | 48'h1;
                default: a = {$urandom(), $urandom()};
            endcase
            send(a, $urandom_range(8, 40), "R7", -1, 0, 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule